// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits behind a pixel digitizer that delivers one pixel per pixel clock on three 8-bit colour channels. It places those pixels either all on output port A or alternately on ports A and B, so downstream logic can run at half the pixel rate. It also generates an output data clock, so the receiving device can latch the ports.

Two configuration inputs control it. The port-select input chooses single-port or dual-port operation. In dual-port mode the timing input chooses between two output timings. In staggered timing, port A is latched on the rising data-clock edge and port B on the falling edge. In simultaneous timing, port A and the data clock are delayed by one pixel period (half a data-clock period), so both ports change together and a single rising data-clock edge latches both.

Configuration is taken only at a pixel-pair boundary, so no pixel is dropped or duplicated. After reset the block always starts in dual-port, simultaneous mode for the first pair. Port B's output enable models the tristate driver: it is off whenever the block runs single-port.

Top module: `pixel_demux`

## Requirements
- R1: In single-port mode, port A is loaded with the pixel captured at every pixel-clock rising edge.
- R2: In dual-port mode, pixels form pairs. The first pixel of a pair (and the first pixel after reset) goes to port A, and the second goes to port B on the following edge.
- R3: `port_b_oe` is 0 after any edge that captured a pixel in single-port mode, and 1 after any edge that captured a pixel in dual-port mode.
- R4: In simultaneous timing (`cfg_simul`=1), port A and port B both update on the edge that captures the second pixel of a pair. `dclk` is low for the pixel period after that edge and high for the next one.
- R5: In staggered timing (`cfg_simul`=0), port A updates on the edge capturing the first pixel and `dclk` is low for the period after it. Port B updates on the next edge and `dclk` is high for the period after that.
- R6: In single-port mode, `dclk` runs at the pixel rate. It is low in the first half of each pixel period (after the rising edge) and high in the second half.
- R7: In single-port mode, `cfg_simul` has no effect on `port_a`, `port_b_oe` or `dclk`.
- R8: `cfg_dual` and `cfg_simul` are sampled only at a pair boundary. A change made in the middle of a dual-port pair takes effect from the next pair. In single-port mode every pixel is a boundary, so a change applies to the next pixel.
- R9: While reset is active, `port_a`, `port_b`, `port_b_oe` and `dclk` are 0. The first pair after reset runs in dual-port, simultaneous mode, whatever the configuration inputs say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dual | input | 1 | 1 selects dual-port output, 0 selects port A only |
| cfg_simul | input | 1 | Dual-port timing: 1 simultaneous, 0 staggered |
| pix_in | input | 24 | Incoming pixel, three 8-bit channels |
| port_a | output | 24 | Output port A |
| port_b | output | 24 | Output port B data |
| port_b_oe | output | 1 | Port B driver enable (0 means high impedance) |
| dclk | output | 1 | Generated data clock |

## Verification
The hardest situation to reach is a configuration change that arrives in the middle of a dual-port pair. Both the pair phase and the change must line up with a known edge. The stimulus releases reset at a known point and counts captured pixels from it. It then flips `cfg_dual` or `cfg_simul` just after the edge that captured the first pixel of a pair, and checks that the pair still finishes under the old setting. Reset is also released with the inputs asking for single-port staggered mode, which exposes the forced dual-port, simultaneous first pair.

// File: rtl/pixel_demux_pkg.sv
package pixel_demux_pkg;

  // A pair ends after the second pixel in dual mode, after every pixel in single mode.
  function automatic logic pair_end_f(input logic dual, input logic slot);
    return !dual || slot;
  endfunction

  // Slot of the next pixel: 0 = port A half of a pair, 1 = port B half.
  function automatic logic next_slot_f(input logic dual, input logic slot);
    return dual && !slot;
  endfunction

  // Dual-mode data clock level for the period after capturing a pixel in this slot.
  function automatic logic dual_dclk_f(input logic slot, input logic simul);
    return slot ^ simul;
  endfunction

endpackage

// File: rtl/pxd_pair_ctrl.sv
module pxd_pair_ctrl #(
  parameter logic RST_DUAL  = 1'b1,
  parameter logic RST_SIMUL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_dual,
  input  logic cfg_simul,
  output logic slot,
  output logic cur_dual,
  output logic cur_simul,
  output logic pair_end
);
  import pixel_demux_pkg::*;

  assign pair_end = pair_end_f(cur_dual, slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= 1'b0;
      cur_dual  <= RST_DUAL;
      cur_simul <= RST_SIMUL;
    end else begin
      slot <= next_slot_f(cur_dual, slot);
      if (pair_end) begin
        cur_dual  <= cfg_dual;
        cur_simul <= cfg_simul;
      end
    end
  end
endmodule

// File: rtl/pxd_lane.sv
module pxd_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         slot,
  input  logic         cur_dual,
  input  logic         cur_simul,
  output logic [W-1:0] a,
  output logic [W-1:0] b
);
  logic [W-1:0] hold_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a      <= '0;
      b      <= '0;
      hold_a <= '0;
    end else if (!cur_dual) begin
      a <= d;
    end else if (!slot) begin
      if (cur_simul) hold_a <= d;
      else           a      <= d;
    end else begin
      b <= d;
      if (cur_simul) a <= hold_a;
    end
  end
endmodule

// File: rtl/pxd_dclk_gen.sv
module pxd_dclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic slot,
  input  logic cur_dual,
  input  logic cur_simul,
  output logic dclk
);
  import pixel_demux_pkg::*;

  logic tog_p;
  logic tog_n;
  logic dual_lvl;
  logic single_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_p    <= 1'b0;
      dual_lvl <= 1'b0;
      single_q <= 1'b0;
    end else begin
      tog_p    <= ~tog_p;
      dual_lvl <= cur_dual & dual_dclk_f(slot, cur_simul);
      single_q <= ~cur_dual;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tog_n <= 1'b0;
    else        tog_n <= tog_p;
  end

  // Single mode: low from rising edge to falling edge, high afterwards.
  assign dclk = single_q ? ~(tog_p ^ tog_n) : dual_lvl;
endmodule

// File: rtl/pixel_demux.sv
module pixel_demux #(
  parameter int   CH_W      = 8,
  parameter int   N_CH      = 3,
  parameter logic RST_DUAL  = 1'b1,
  parameter logic RST_SIMUL = 1'b1,
  localparam int  PIX_W     = CH_W * N_CH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic             cfg_simul,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] port_a,
  output logic [PIX_W-1:0] port_b,
  output logic             port_b_oe,
  output logic             dclk
);
  logic slot;
  logic cur_dual;
  logic cur_simul;
  logic pair_end;

  pxd_pair_ctrl #(.RST_DUAL(RST_DUAL), .RST_SIMUL(RST_SIMUL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_simul(cfg_simul),
    .slot(slot), .cur_dual(cur_dual), .cur_simul(cur_simul), .pair_end(pair_end)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    pxd_lane #(.W(CH_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .d(pix_in[c*CH_W +: CH_W]),
      .slot(slot), .cur_dual(cur_dual), .cur_simul(cur_simul),
      .a(port_a[c*CH_W +: CH_W]),
      .b(port_b[c*CH_W +: CH_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_b_oe <= 1'b0;
    else        port_b_oe <= cur_dual;
  end

  pxd_dclk_gen u_dclk (
    .clk(clk), .rst_n(rst_n), .slot(slot), .cur_dual(cur_dual),
    .cur_simul(cur_simul), .dclk(dclk)
  );
endmodule

// File: rtl/pixel_demux_chk.sv
module pixel_demux_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] pix_in,
  input logic [PIX_W-1:0] port_a,
  input logic [PIX_W-1:0] port_b,
  input logic             port_b_oe,
  input logic             dclk,
  input logic             slot,
  input logic             cur_dual,
  input logic             cur_simul,
  input logic             pair_end
);
  a_r1_single_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_dual |=> port_a == $past(pix_in));

  a_r2_second_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    cur_dual && slot |=> port_b == $past(pix_in));

  a_r2_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_dual |=> !slot);

  a_r3_b_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_dual |=> !port_b_oe);

  a_r3_b_on: assert property (@(posedge clk) disable iff (!rst_n)
    cur_dual |=> port_b_oe);

  a_r4_both_ports: assert property (@(posedge clk) disable iff (!rst_n)
    cur_dual && cur_simul && slot |=> port_a == $past(pix_in, 2) && !dclk);

  a_r5_stagger_a: assert property (@(posedge clk) disable iff (!rst_n)
    cur_dual && !cur_simul && !slot |=> port_a == $past(pix_in) && !dclk);

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_end |=> $stable(cur_dual) && $stable(cur_simul));
endmodule

bind pixel_demux pixel_demux_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .port_a(port_a), .port_b(port_b),
  .port_b_oe(port_b_oe), .dclk(dclk), .slot(slot), .cur_dual(cur_dual),
  .cur_simul(cur_simul), .pair_end(pair_end)
);

// File: tb/pixel_demux_bench.sv
module pixel_demux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dual = 1'b1;
  logic        cfg_simul = 1'b1;
  logic [23:0] pix_in = '0;
  logic [23:0] port_a, port_b;
  logic        port_b_oe, dclk;

  int tests = 0;
  int fails = 0;
  int ncap;
  logic [23:0] a1, b1;
  logic        oe1, d1, d2;

  always #2.5 clk = ~clk;

  pixel_demux u_pixel_demux (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_simul(cfg_simul),
    .pix_in(pix_in), .port_a(port_a), .port_b(port_b),
    .port_b_oe(port_b_oe), .dclk(dclk)
  );

  function automatic logic [23:0] pixf(input int i);
    return 24'(i * 40503 + 7);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at pixel %0d: got %h expected %h", req, ncap, act, exp);
    end
  endtask

  // One pixel edge: drive next pixel 1 ns after the edge, sample at +2 ns and +4 ns.
  task automatic step();
    @(posedge clk);
    ncap++;
    #1 pix_in = pixf(ncap + 1);
    #1 a1 = port_a; b1 = port_b; oe1 = port_b_oe; d1 = dclk;
    #2 d2 = dclk;
  endtask

  task automatic do_reset(input logic dual, input logic simul);
    rst_n = 1'b0;
    cfg_dual = dual;
    cfg_simul = simul;
    pix_in = pixf(0);
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    ncap = -1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    pix_in = 24'hABCDEF;
    repeat (2) @(posedge clk);
    #2;
    chk("R9 reset port_a", 32'(port_a), 0);
    chk("R9 reset port_b", 32'(port_b), 0);
    chk("R9 reset oe", 32'(port_b_oe), 0);
    chk("R9 reset dclk", 32'(dclk), 0);
  endtask

  task automatic t_defaults();
    do_reset(1'b0, 1'b0);
    step(); step();
    chk("R9 default simul pair A", 32'(a1), 32'(pixf(0)));
    chk("R9 default dual pair B", 32'(b1), 32'(pixf(1)));
    chk("R9 default oe", 32'(oe1), 1);
    step();
    chk("R9 then single A", 32'(a1), 32'(pixf(2)));
    chk("R9 then single oe", 32'(oe1), 0);
  endtask

  task automatic t_single(input logic simul);
    do_reset(1'b0, simul);
    step(); step();
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R1 single port_a", 32'(a1), 32'(pixf(ncap)));
      chk("R3 single oe off", 32'(oe1), 0);
      chk("R6 dclk first half low", 32'(d1), 0);
      chk("R6 dclk second half high", 32'(d2), 1);
      if (simul) chk("R7 simul ignored", 32'(a1), 32'(pixf(ncap)));
    end
  endtask

  task automatic t_stagger();
    do_reset(1'b1, 1'b0);
    step(); step();
    for (int k = 0; k < 8; k++) begin
      step();
      if (ncap % 2 == 0) begin
        chk("R5 stagger A", 32'(a1), 32'(pixf(ncap)));
        chk("R2 B holds older", 32'(b1), 32'(pixf(ncap - 1)));
        chk("R5 dclk low after A", 32'({d1, d2}), 0);
      end else begin
        chk("R2 A held", 32'(a1), 32'(pixf(ncap - 1)));
        chk("R5 stagger B", 32'(b1), 32'(pixf(ncap)));
        chk("R5 dclk high after B", 32'({d1, d2}), 3);
      end
      chk("R3 dual oe on", 32'(oe1), 1);
    end
  endtask

  task automatic t_simul();
    do_reset(1'b1, 1'b1);
    step();
    for (int k = 0; k < 8; k++) begin
      step();
      if (ncap % 2 == 1) begin
        chk("R4 simul A", 32'(a1), 32'(pixf(ncap - 1)));
        chk("R4 simul B", 32'(b1), 32'(pixf(ncap)));
        chk("R4 dclk low", 32'({d1, d2}), 0);
      end else begin
        chk("R4 A held", 32'(a1), 32'(pixf(ncap - 2)));
        chk("R4 B held", 32'(b1), 32'(pixf(ncap - 1)));
        chk("R4 dclk high", 32'({d1, d2}), 3);
      end
    end
  endtask

  task automatic t_switch();
    do_reset(1'b1, 1'b0);
    for (int k = 0; k < 5; k++) step();   // last captured pixel 4, first of a pair
    cfg_dual = 1'b0;                      // mid-pair request
    step();
    chk("R8 pair finishes on B", 32'(b1), 32'(pixf(5)));
    chk("R8 pair A kept", 32'(a1), 32'(pixf(4)));
    chk("R8 oe still on", 32'(oe1), 1);
    step();
    chk("R8 single from next pair", 32'(a1), 32'(pixf(6)));
    chk("R8 oe off", 32'(oe1), 0);
    cfg_dual = 1'b1;
    cfg_simul = 1'b1;
    step();
    chk("R8 single change next pixel", 32'(a1), 32'(pixf(7)));
    step();
    chk("R8 simul pair A waits", 32'(a1), 32'(pixf(7)));
    chk("R8 dual oe on", 32'(oe1), 1);
    cfg_simul = 1'b0;                     // mid-pair timing change
    step();
    chk("R8 simul pair A", 32'(a1), 32'(pixf(8)));
    chk("R8 simul pair B", 32'(b1), 32'(pixf(9)));
    step();
    chk("R8 stagger next pair", 32'(a1), 32'(pixf(10)));
  endtask

  initial begin
    #200000;
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    ncap = -1;
    t_reset();
    t_defaults();
    t_single(1'b0);
    t_single(1'b1);
    t_stagger();
    t_simul();
    t_switch();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule